// File: doc/BRIEF.md
# SECDED-Protected Memory Access Path with Byte-Merge Writes

This block sits between a requester and a memory whose every location holds a 64-bit data word plus 8 check bits (72 bits in all). A full-word write computes the check bits and stores both together in one memory cycle. A read decodes the stored word. A single flipped bit anywhere in the 72 bits is repaired before the data reaches the requester. Any two flipped bits are reported as uncorrectable. The code is a Hamming code with 7 position bits plus one overall parity bit.

A write that enables fewer than all eight bytes cannot produce valid check bits on its own while protection is on. The block therefore turns such a write into a locked sequence. It reads the old word, corrects it, merges the enabled new bytes over it, and writes the result back with fresh check bits. The requester sees the block as busy until the write-back is issued. Protection is switched by a run-time input. With it off, check bits are neither produced nor examined, and partial writes go straight to memory under their byte enables.

Top module: `eccMemPath`

## Requirements
- R1: With protection on, a write with all eight byte enables issues a single memory write in the accepting cycle with all nine lanes enabled (memByteEn = 9'h1FF). The data sits in memWData[63:0] and the check bits in memWData[71:64]. Reading that word back unaltered returns the same data with neither error flag set.
- R2: With protection on, a read of a stored word in which any one of the 72 bits is flipped returns the original data with rspCorrectable high and rspUncorrectable low. Both are one-cycle signals coincident with rspValid.
- R3: With protection on, a read of a stored word in which any two distinct bits are flipped raises rspUncorrectable with rspValid, and rspCorrectable stays low. The two flags are never high together.
- R4: With protection on, a write with fewer than eight byte enables set issues a memory read in the accepting cycle and a memory write three cycles later. Byte k (bits 8k+7:8k) is taken from the request when enable k is set and from the corrected old word otherwise. The written word carries fresh check bits, so a later protected read returns the merged data with no flags. The response comes four cycles after acceptance, with rspCorrectable high if the old word needed correction.
- R5: reqReady is high in idle and low for the three cycles after a read-merge-write is accepted. During that time no request is taken.
- R6: If the read of a read-merge-write finds an uncorrectable error, no memory write is issued. The memory word is left unchanged, and the response arrives two cycles after acceptance with rspUncorrectable high.
- R7: With protection off, a read returns memRData[63:0] unmodified and never raises either error flag, whatever the check bits hold.
- R8: With protection off, every write, partial or full, is a single memory write in the accepting cycle. Data lanes are enabled as memByteEn[7:0] = reqByteEn and the check lane memByteEn[8] is low, so the stored check bits are untouched. The response comes one cycle after acceptance.
- R9: A plain read responds with rspValid two cycles after acceptance. A direct write responds one cycle after acceptance.
- R10: Neither error flag is ever high without rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccEnable | input | 1 | Protection on (1) or off (0), sampled when a request is accepted |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | 64 | Write data |
| reqByteEn | input | 8 | Write byte enables, bit k for bits 8k+7:8k |
| rspValid | output | 1 | One-cycle completion of a request |
| rspData | output | 64 | Read data (corrected); merged word for a read-merge-write; zero otherwise |
| rspCorrectable | output | 1 | A single-bit error was repaired |
| rspUncorrectable | output | 1 | An uncorrectable error was found |
| memEn | output | 1 | Memory command valid |
| memWe | output | 1 | Memory command is a write |
| memAddr | output | ADDR_W | Memory word address |
| memByteEn | output | 9 | Lane enables: [7:0] data bytes, [8] check byte |
| memWData | output | 72 | Write word: [63:0] data, [71:64] check bits |
| memRData | input | 72 | Read word, valid the cycle after a read command |

## Verification
The bench flips every single bit of a stored word, including check bits and the overall parity bit. A decoder that confuses check positions with data positions would then return damaged data or raise the wrong flag. It also flips every pair of the 72 bits. Miscounting the overall parity there would show up as a false correction, which silently returns bad data. Partial writes are swept over all byte-enable patterns short of a full word. Each result is read back under protection, so a wrong merge lane or stale check bits shows up as damaged data or a spurious flag. An old word holding a double error must leave memory untouched. Finally, with protection off, the check byte must survive partial writes and raw data must come back unrepaired.

// File: rtl/eccMemPkg.sv
package eccMemPkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int LANES  = DATA_W / 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int HAM_W  = CHK_W - 1;
  localparam int LAST_POS = DATA_W + HAM_W;  // highest used code position

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MERGE, ST_WRITE} rmwState_t;

  typedef struct packed {
    logic latchReq;
    logic issueRead;
    logic writeDirect;
    logic writeMerged;
    logic captureRead;
    logic loadMerge;
    logic rspRead;
    logic rspDirect;
    logic rspAbort;
    logic rspRmwDone;
  } ctlStrobe_t;

  // Check bits: [6:0] position parities, [7] overall parity over data and [6:0]
  function automatic logic [CHK_W-1:0] secdedEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int di;
    h  = '0;
    di = 0;
    for (int pos = 1; pos <= LAST_POS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int b = 0; b < HAM_W; b++)
          if (pos[b]) h[b] = h[b] ^ d[di];
        di++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  // Data bit to flip for a given syndrome (zero when it names a check bit)
  function automatic logic [DATA_W-1:0] repairMask(input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] m;
    int di;
    m  = '0;
    di = 0;
    for (int pos = 1; pos <= LAST_POS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (pos[HAM_W-1:0] == syn) m[di] = 1'b1;
        di++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/eccMemCtl.sv
module eccMemCtl
  import eccMemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [7:0] reqByteEn,
  input  logic       eccEnable,
  input  logic       rdUncorr,
  output logic       reqReady,
  output ctlStrobe_t strobe
);
  rmwState_t state, stateNext;
  logic rmwQ;
  logic partialReq;

  assign partialReq = reqWrite && eccEnable && (reqByteEn != 8'hFF);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    reqReady  = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (!reqWrite || partialReq) begin
            strobe.issueRead = 1'b1;
            stateNext = ST_READ;
          end else begin
            strobe.writeDirect = 1'b1;
            strobe.rspDirect   = 1'b1;
          end
        end
      end
      ST_READ: begin
        strobe.captureRead = 1'b1;
        if (!rmwQ) begin
          strobe.rspRead = 1'b1;
          stateNext = ST_IDLE;
        end else if (rdUncorr) begin
          strobe.rspAbort = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_MERGE;
        end
      end
      ST_MERGE: begin
        strobe.loadMerge = 1'b1;
        stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.writeMerged = 1'b1;
        strobe.rspRmwDone  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rmwQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.latchReq) rmwQ <= partialReq;
    end
  end
endmodule

// File: rtl/eccMemDp.sv
module eccMemDp
  import eccMemPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic                eccEnable,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [LANES-1:0]    reqByteEn,
  input  logic [WORD_W-1:0]   memRData,
  output logic                memEn,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [LANES:0]      memByteEn,
  output logic [WORD_W-1:0]   memWData,
  output logic                rdUncorr,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspCorrectable,
  output logic                rspUncorrectable
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdWordQ, mergedQ, mergeWord;
  logic [LANES-1:0]  beQ;
  logic [CHK_W-1:0]  checkQ;
  logic              eccQ, corrQ;

  // Decode of the word returned by memory
  logic [DATA_W-1:0] rawData, decWord;
  logic [CHK_W-1:0]  rawChk, recomputed;
  logic [HAM_W-1:0]  syndrome;
  logic              parityOdd, decSingle, decDouble, synInRange;

  assign rawData    = memRData[DATA_W-1:0];
  assign rawChk     = memRData[WORD_W-1:DATA_W];
  assign recomputed = secdedEncode(rawData);
  assign syndrome   = recomputed[HAM_W-1:0] ^ rawChk[HAM_W-1:0];
  assign parityOdd  = ^memRData;
  assign synInRange = (syndrome <= HAM_W'(LAST_POS));

  always_comb begin
    decSingle = eccQ && parityOdd && synInRange;
    decDouble = eccQ && ((!parityOdd && syndrome != '0) || (parityOdd && !synInRange));
    decWord   = decSingle ? (rawData ^ repairMask(syndrome)) : rawData;
  end
  assign rdUncorr = decDouble;

  // Byte merge of request data over the corrected old word
  for (genvar g = 0; g < LANES; g++) begin : gMerge
    assign mergeWord[8*g +: 8] = beQ[g] ? dataQ[8*g +: 8] : rdWordQ[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      beQ     <= '0;
      eccQ    <= 1'b0;
      rdWordQ <= '0;
      corrQ   <= 1'b0;
      mergedQ <= '0;
      checkQ  <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
        beQ   <= reqByteEn;
        eccQ  <= eccEnable;
      end
      if (strobe.captureRead) begin
        rdWordQ <= decWord;
        corrQ   <= decSingle;
      end
      if (strobe.loadMerge) begin
        mergedQ <= mergeWord;
        checkQ  <= secdedEncode(mergeWord);
      end
    end
  end

  // Memory command
  always_comb begin
    memEn     = strobe.issueRead | strobe.writeDirect | strobe.writeMerged;
    memWe     = strobe.writeDirect | strobe.writeMerged;
    memAddr   = strobe.writeMerged ? addrQ : reqAddr;
    memWData  = {(eccEnable ? secdedEncode(reqData) : '0), reqData};
    memByteEn = '0;
    if (strobe.writeMerged) begin
      memWData  = {checkQ, mergedQ};
      memByteEn = '1;
    end else if (strobe.writeDirect) begin
      memByteEn = eccEnable ? '1 : {1'b0, reqByteEn};
    end
  end

  // Response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid         <= 1'b0;
      rspData          <= '0;
      rspCorrectable   <= 1'b0;
      rspUncorrectable <= 1'b0;
    end else begin
      rspValid         <= strobe.rspRead | strobe.rspDirect | strobe.rspAbort | strobe.rspRmwDone;
      rspCorrectable   <= (strobe.rspRead & decSingle) | (strobe.rspRmwDone & corrQ);
      rspUncorrectable <= (strobe.rspRead | strobe.rspAbort) & decDouble;
      rspData          <= strobe.rspRead ? decWord : (strobe.rspRmwDone ? mergedQ : '0);
    end
  end
endmodule

// File: rtl/eccMemPath.sv
module eccMemPath
  import eccMemPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEnable,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqData,
  input  logic [7:0]        reqByteEn,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              rspCorrectable,
  output logic              rspUncorrectable,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [8:0]        memByteEn,
  output logic [71:0]       memWData,
  input  logic [71:0]       memRData
);
  ctlStrobe_t strobe;
  logic rdUncorr;

  eccMemCtl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqByteEn(reqByteEn), .eccEnable(eccEnable), .rdUncorr(rdUncorr),
    .reqReady(reqReady), .strobe(strobe)
  );

  eccMemDp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eccEnable(eccEnable),
    .reqAddr(reqAddr), .reqData(reqData), .reqByteEn(reqByteEn),
    .memRData(memRData), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWData(memWData), .rdUncorr(rdUncorr),
    .rspValid(rspValid), .rspData(rspData), .rspCorrectable(rspCorrectable),
    .rspUncorrectable(rspUncorrectable)
  );
endmodule

// File: rtl/eccMemPathChk.sv
module eccMemPathChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              eccEnable,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [63:0]       reqData,
  input logic [7:0]        reqByteEn,
  input logic              rspValid,
  input logic [63:0]       rspData,
  input logic              rspCorrectable,
  input logic              rspUncorrectable,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [8:0]        memByteEn,
  input logic [71:0]       memWData,
  input logic [71:0]       memRData
);
  logic accepted;
  assign accepted = reqValid && reqReady;

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspCorrectable || rspUncorrectable) |-> rspValid);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(rspCorrectable && rspUncorrectable));

  assert_full_write_lanes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqWrite && eccEnable && reqByteEn == 8'hFF) |-> (memEn && memWe && memByteEn == 9'h1FF));

  assert_partial_reads_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqWrite && eccEnable && reqByteEn != 8'hFF) |-> (memEn && !memWe));

  assert_busy_after_rmw_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqWrite && eccEnable && reqByteEn != 8'hFF) |=> !reqReady);

  assert_plain_check_lane_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqWrite && !eccEnable) |-> (memEn && memWe && !memByteEn[8] && memByteEn[7:0] == reqByteEn));

  assert_direct_write_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqWrite && (!eccEnable || reqByteEn == 8'hFF)) |=> rspValid);

  assert_read_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqWrite) |-> ##2 rspValid);

  assert_off_no_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!eccEnable && $past(!eccEnable) && $past(!eccEnable, 2) && $past(!eccEnable, 3) && $past(!eccEnable, 4))
      |-> !(rspCorrectable || rspUncorrectable));
endmodule

bind eccMemPath eccMemPathChk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_eccMemPath.sv
module sim_eccMemPath;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccEnable = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [63:0] reqData = '0;
  logic [7:0] reqByteEn = '0;
  logic reqReady, rspValid, rspCorrectable, rspUncorrectable;
  logic [63:0] rspData;
  logic memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [8:0] memByteEn;
  logic [71:0] memWData;
  logic [71:0] memRData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  eccMemPath #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .eccEnable(eccEnable), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .reqByteEn(reqByteEn), .rspValid(rspValid), .rspData(rspData),
    .rspCorrectable(rspCorrectable), .rspUncorrectable(rspUncorrectable),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memByteEn(memByteEn),
    .memWData(memWData), .memRData(memRData)
  );

  // Memory model with error injection
  logic [71:0] mem [16];
  logic injGo = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [71:0] injMask = '0;
  int memWrites = 0;

  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (injGo) mem[injAddr] <= mem[injAddr] ^ injMask;
    else if (memEn) begin
      if (memWe) begin
        memWrites <= memWrites + 1;
        for (int k = 0; k < 9; k++)
          if (memByteEn[k]) mem[memAddr][8*k +: 8] <= memWData[8*k +: 8];
      end else memRData <= mem[memAddr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    injAddr = a; injMask = m; injGo = 1'b1;
    @(negedge clk);
    injGo = 1'b0;
  endtask

  task automatic runReq(input logic wr, input logic [AW-1:0] a, input logic [63:0] d,
                        input logic [7:0] be, output int lat, output logic [63:0] rd,
                        output logic c, output logic u, output bit busyOk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d; reqByteEn = be;
    lat = 0; busyOk = 1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 20) begin
      if (reqReady) busyOk = 0;
      @(negedge clk);
      lat++;
    end
    if (lat < 4 && reqWrite && eccEnable && be != 8'hFF && rspValid && !rspUncorrectable) busyOk = 0;
    rd = rspData; c = rspCorrectable; u = rspUncorrectable;
  endtask

  function automatic logic [63:0] pat(input int n);
    return 64'h0123_4567_89AB_CDEF ^ (64'(n) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  function automatic logic [63:0] mergeBytes(input logic [63:0] oldW, input logic [63:0] newW, input logic [7:0] be);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = be[k] ? newW[8*k +: 8] : oldW[8*k +: 8];
    return r;
  endfunction

  initial begin
    int lat;
    logic [63:0] rd;
    logic c, u;
    bit busy;
    logic [71:0] snap;
    int wcount;

    repeat (3) @(negedge clk);
    // Reset state
    chk(reqReady == 1'b1, "R5 reset ready", 72'(reqReady), 72'd1);
    chk(rspValid == 1'b0 && memEn == 1'b0, "R9 reset idle outputs", {70'd0, rspValid, memEn}, 72'd0);
    rstN = 1'b1;

    // R1 full write and clean read-back
    runReq(1, 1, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, lat, rd, c, u, busy);
    chk(lat == 1, "R9 direct write latency", 72'(lat), 72'd1);
    chk(mem[1][63:0] == 64'hDEAD_BEEF_0BAD_F00D, "R1 stored data", mem[1], 72'hDEAD_BEEF_0BAD_F00D);
    runReq(0, 1, '0, '0, lat, rd, c, u, busy);
    chk(lat == 2, "R9 read latency", 72'(lat), 72'd2);
    chk(rd == 64'hDEAD_BEEF_0BAD_F00D && !c && !u, "R1 clean read-back", {c, u, 6'd0, rd}, {8'd0, 64'hDEAD_BEEF_0BAD_F00D});

    // R2 every single-bit flip
    for (int b = 0; b < 72; b++) begin
      runReq(1, 3, pat(b), 8'hFF, lat, rd, c, u, busy);
      inject(3, 72'd1 << b);
      runReq(0, 3, '0, '0, lat, rd, c, u, busy);
      chk(rd == pat(b) && c && !u, $sformatf("R2 single flip bit %0d", b), {c, u, 6'd0, rd}, {8'h80, pat(b)});
    end

    // R3 every pair of flips
    runReq(1, 4, pat(99), 8'hFF, lat, rd, c, u, busy);
    for (int i = 0; i < 72; i++) begin
      for (int j = i + 1; j < 72; j++) begin
        inject(4, (72'd1 << i) | (72'd1 << j));
        runReq(0, 4, '0, '0, lat, rd, c, u, busy);
        chk(u && !c && lat == 2, $sformatf("R3 double flip %0d,%0d", i, j), {c, u, 6'd0, 64'(lat)}, {8'h40, 64'd2});
        inject(4, (72'd1 << i) | (72'd1 << j));
      end
    end

    // R4 / R5 partial writes over all enable patterns short of full
    for (int be = 0; be < 255; be++) begin
      runReq(1, 2, pat(be + 300), 8'hFF, lat, rd, c, u, busy);
      runReq(1, 2, pat(be + 700), 8'(be), lat, rd, c, u, busy);
      chk(lat == 4 && !c && !u, $sformatf("R4 rmw latency be=%02h", be), 72'(lat), 72'd4);
      chk(busy, $sformatf("R5 busy during rmw be=%02h", be), 72'(busy), 72'd1);
      runReq(0, 2, '0, '0, lat, rd, c, u, busy);
      chk(rd == mergeBytes(pat(be + 300), pat(be + 700), 8'(be)) && !c && !u,
          $sformatf("R4 merged read-back be=%02h", be), {c, u, 6'd0, rd},
          {8'd0, mergeBytes(pat(be + 300), pat(be + 700), 8'(be))});
    end

    // R4 partial write over a word with a single error in an untouched byte
    runReq(1, 5, 64'h1111_2222_3333_4444, 8'hFF, lat, rd, c, u, busy);
    inject(5, 72'd1 << 60);
    runReq(1, 5, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F, lat, rd, c, u, busy);
    chk(c && !u && lat == 4, "R4 rmw corrected flag", {c, u, 6'd0, 64'(lat)}, {8'h80, 64'd4});
    runReq(0, 5, '0, '0, lat, rd, c, u, busy);
    chk(rd == 64'h1111_2222_CCCC_DDDD && !c && !u, "R4 rmw repaired merge", {c, u, 6'd0, rd}, {8'd0, 64'h1111_2222_CCCC_DDDD});

    // R6 partial write over an uncorrectable word
    runReq(1, 6, 64'h5555_6666_7777_8888, 8'hFF, lat, rd, c, u, busy);
    inject(6, (72'd1 << 3) | (72'd1 << 40));
    snap = mem[6];
    wcount = memWrites;
    runReq(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01, lat, rd, c, u, busy);
    chk(u && !c && lat == 2, "R6 abort flag and latency", {c, u, 6'd0, 64'(lat)}, {8'h40, 64'd2});
    repeat (3) @(negedge clk);
    chk(mem[6] == snap && memWrites == wcount, "R6 memory untouched", mem[6], snap);

    // R7 protection off: raw data, no flags
    eccEnable = 1'b0;
    inject(6, 72'd1 << 10);
    runReq(0, 6, '0, '0, lat, rd, c, u, busy);
    chk(rd == (snap[63:0] ^ 64'h400) && !c && !u, "R7 raw read triple flip", {c, u, 6'd0, rd}, {8'd0, snap[63:0] ^ 64'h400});
    runReq(0, 1, '0, '0, lat, rd, c, u, busy);
    chk(rd == 64'hDEAD_BEEF_0BAD_F00D && !c && !u, "R7 raw read clean", {c, u, 6'd0, rd}, {8'd0, 64'hDEAD_BEEF_0BAD_F00D});

    // R8 protection off: direct partial writes keep the check byte
    for (int k = 0; k < 9; k++) begin
      logic [7:0] be8;
      be8 = (k == 8) ? 8'h5A : 8'(1 << k);
      snap = mem[7];
      runReq(1, 7, pat(k + 900), be8, lat, rd, c, u, busy);
      chk(lat == 1, $sformatf("R8 direct latency be=%02h", be8), 72'(lat), 72'd1);
      chk(mem[7] == {snap[71:64], mergeBytes(snap[63:0], pat(k + 900), be8)},
          $sformatf("R8 lanes and check byte be=%02h", be8), mem[7],
          {snap[71:64], mergeBytes(snap[63:0], pat(k + 900), be8)});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule